// File: doc/BRIEF.md
# Chained DMA Channel Context Keeper

This block keeps the working state of several DMA channels that sit behind one controller. Each channel has three values. The first is a program pointer to its next descriptor in memory. The second is the address of the buffer it is working through. The third is the number of bytes left in that buffer. A datapath outside the block reports each transfer it wants to make as a length. The block accepts at most one such update per clock. It moves the buffer address forward and the count down using one adder and one subtractor that all channels share.

When a buffer runs dry, the channel reads its next descriptor from memory through a simple request/grant read port. It then carries on with no host involvement. A descriptor is two 32-bit words at an 8-byte aligned address. The first word is the buffer address. The second word holds the byte count in its low bits and a last-descriptor flag in its top bit. Loading a descriptor also moves the program pointer forward by 8, and this too goes through the shared adder. When the last descriptor of a chain is used up, the channel pulses `done` for one cycle and goes back to idle.

Top module: `dma_chain_ctx`

## Requirements
- R1: After reset every channel is idle: `active`, `ready`, `done`, `xfer_ack` and `mem_req` are all low.
- R2: A `start` pulse on an idle channel loads its program pointer from `start_ptr` and begins a descriptor fetch at that pointer. A `start` on a channel that is already active is ignored and causes no fetch.
- R3: A descriptor fetch reads two words in order. The first is at the pointer with bits 2:0 cleared and gives the buffer address. The second is at that address with bit 2 set; its bits 15:0 give the byte count and its bit 31 marks the last descriptor. Each read holds `mem_req` and `mem_addr` until `mem_gnt`, and its data is taken on a later `mem_rvalid`.
- R4: After a descriptor is loaded the program pointer advances by 8, so the next fetch of that channel starts 8 bytes further on.
- R5: An accepted transfer of N bytes (`xfer_ack` high) adds N to `buf_addr` and subtracts N from `buf_cnt` at the next clock edge.
- R6: A transfer request whose length is 0 or greater than the remaining count is never acknowledged and leaves `buf_addr` and `buf_cnt` unchanged.
- R7: When the count reaches zero on a descriptor that is not the last, the channel drops `ready` and fetches the next descriptor on its own, then resumes with the new address and count.
- R8: When the count reaches zero on the last descriptor, the channel raises `done` for exactly one cycle and returns to idle (`active` low).
- R9: A descriptor with a count of zero is used up at once. It is followed by the next fetch, or by `done` if it is the last.
- R10: At most one channel's transfer is acknowledged per cycle. When several channels request together, grants rotate round-robin.
- R11: At most one descriptor fetch is in progress at a time. The two words of one descriptor are read back to back, with no read for another channel between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | NCH | Per-channel start pulse |
| start_ptr | input | NCH*AW | Per-channel first descriptor pointer |
| xfer_req | input | NCH | Per-channel transfer request |
| xfer_len | input | NCH*CW | Per-channel transfer length in bytes |
| xfer_ack | output | NCH | Transfer accepted this cycle |
| active | output | NCH | Channel is not idle |
| ready | output | NCH | Channel holds a valid buffer and accepts transfers |
| done | output | NCH | One-cycle pulse when a chain completes |
| buf_addr | output | NCH*AW | Current buffer address per channel |
| buf_cnt | output | NCH*CW | Remaining byte count per channel |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Descriptor word address |
| mem_gnt | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | AW | Read data |

## Verification
The bench walks a two-descriptor chain and checks the moment a buffer empties. A design that failed to refetch there would stall with `ready` low. One that skipped the pointer advance would read the same descriptor again, which the bench sees in the logged fetch addresses. A zero-count descriptor is placed both mid-chain and at the end of a chain, where a faulty design would hang waiting for a transfer that can never be accepted. The bench also holds oversized and zero-length requests to catch a design that accepts them and wraps the count. It starts two channels in the same cycle to catch interleaved descriptor reads or a grant that does not rotate. Grant stalls on the read port check that the request and address are held until accepted.

// File: rtl/dma_chain_ctx.sv
module dma_chain_ctx #(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    start,
  input  logic [NCH*AW-1:0] start_ptr,
  input  logic [NCH-1:0]    xfer_req,
  input  logic [NCH*CW-1:0] xfer_len,
  output logic [NCH-1:0]    xfer_ack,
  output logic [NCH-1:0]    active,
  output logic [NCH-1:0]    ready,
  output logic [NCH-1:0]    done,
  output logic [NCH*AW-1:0] buf_addr,
  output logic [NCH*CW-1:0] buf_cnt,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [AW-1:0]     mem_rdata
);

  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_NEED, S_FETCH, S_ADV, S_RUN} ch_st_t;
  typedef enum logic [2:0] {F_IDLE, F_REQ0, F_WAIT0, F_REQ1, F_WAIT1} f_st_t;

  ch_st_t         st   [NCH];
  logic [AW-1:0]  pp   [NCH];
  logic [AW-1:0]  ba   [NCH];
  logic [CW-1:0]  cnt  [NCH];
  logic [CW-1:0]  lens [NCH];
  logic [NCH-1:0] lastd, done_q, ar_elig, need, in_fetch;
  logic [IW:0]    ar_pick, f_pick;
  logic [IW-1:0]  ar_ch, ar_last, f_ch, f_last;
  logic           ar_go, ar_adv, ar_end, f_go;
  logic [AW-1:0]  inc_a, inc_b, inc_y, f_word0;
  logic [CW-1:0]  dec_y;
  f_st_t          fs;
  logic           rsvd_unused;

  function automatic logic [IW:0] rr_pick(input logic [NCH-1:0] m, input logic [IW-1:0] prev);
    logic [IW:0] r;
    int idx;
    r = '0;
    for (int k = NCH; k >= 1; k--) begin
      idx = (int'(prev) + k) % NCH;
      if (m[idx]) r = {1'b1, idx[IW-1:0]};
    end
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      lens[i]     = xfer_len[i*CW +: CW];
      need[i]     = (st[i] == S_NEED);
      in_fetch[i] = (st[i] == S_FETCH);
      ar_elig[i]  = (st[i] == S_ADV) ||
                    (st[i] == S_RUN && xfer_req[i] && lens[i] != '0 && lens[i] <= cnt[i]);
      active[i]   = (st[i] != S_IDLE);
      ready[i]    = (st[i] == S_RUN);
      buf_addr[i*AW +: AW] = ba[i];
      buf_cnt[i*CW +: CW]  = cnt[i];
    end
  end

  assign ar_pick = rr_pick(ar_elig, ar_last);
  assign ar_go   = ar_pick[IW];
  assign ar_ch   = ar_pick[IW-1:0];
  assign ar_adv  = (st[ar_ch] == S_ADV);
  assign inc_a   = ar_adv ? pp[ar_ch] : ba[ar_ch];
  assign inc_b   = ar_adv ? AW'(8) : AW'(lens[ar_ch]);
  assign inc_y   = inc_a + inc_b;
  assign dec_y   = cnt[ar_ch] - lens[ar_ch];
  assign ar_end  = ar_adv ? (cnt[ar_ch] == '0) : (dec_y == '0);

  always_comb
    for (int i = 0; i < NCH; i++)
      xfer_ack[i] = ar_go && (ar_ch == IW'(i)) && (st[i] == S_RUN);

  assign f_pick   = rr_pick(need, f_last);
  assign f_go     = f_pick[IW];
  assign mem_req  = (fs == F_REQ0) || (fs == F_REQ1);
  assign mem_addr = {pp[f_ch][AW-1:3], (fs == F_REQ1), 2'b00};
  assign done     = done_q;
  assign rsvd_unused = ^mem_rdata[AW-2:CW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        st[i]  <= S_IDLE;
        pp[i]  <= '0;
        ba[i]  <= '0;
        cnt[i] <= '0;
      end
      lastd   <= '0;
      done_q  <= '0;
      ar_last <= IW'(NCH-1);
      f_last  <= IW'(NCH-1);
      f_ch    <= '0;
      f_word0 <= '0;
      fs      <= F_IDLE;
    end else begin
      done_q <= '0;
      for (int i = 0; i < NCH; i++)
        if (st[i] == S_IDLE && start[i]) begin
          pp[i] <= start_ptr[i*AW +: AW];
          st[i] <= S_NEED;
        end

      if (ar_go) begin
        ar_last <= ar_ch;
        if (ar_adv) pp[ar_ch] <= inc_y;
        else begin
          ba[ar_ch]  <= inc_y;
          cnt[ar_ch] <= dec_y;
        end
        if (ar_end) begin
          if (lastd[ar_ch]) begin
            st[ar_ch]     <= S_IDLE;
            done_q[ar_ch] <= 1'b1;
          end else st[ar_ch] <= S_NEED;
        end else if (ar_adv) st[ar_ch] <= S_RUN;
      end

      case (fs)
        F_IDLE: if (f_go) begin
          f_ch   <= f_pick[IW-1:0];
          f_last <= f_pick[IW-1:0];
          st[f_pick[IW-1:0]] <= S_FETCH;
          fs <= F_REQ0;
        end
        F_REQ0:  if (mem_gnt) fs <= F_WAIT0;
        F_WAIT0: if (mem_rvalid) begin
          f_word0 <= mem_rdata;
          fs <= F_REQ1;
        end
        F_REQ1:  if (mem_gnt) fs <= F_WAIT1;
        F_WAIT1: if (mem_rvalid) begin
          ba[f_ch]    <= f_word0;
          cnt[f_ch]   <= mem_rdata[CW-1:0];
          lastd[f_ch] <= mem_rdata[AW-1];
          st[f_ch]    <= S_ADV;
          fs <= F_IDLE;
        end
        default: fs <= F_IDLE;
      endcase
    end
  end

  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(xfer_ack));

  // R11
  one_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(in_fetch) <= 1);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done != '0) |=> ((done & $past(done)) == '0));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & active) == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack[g] |=> (buf_cnt[g*CW +: CW] == $past(buf_cnt[g*CW +: CW]) - $past(xfer_len[g*CW +: CW])));
    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack[g] |=> (buf_addr[g*AW +: AW] == $past(buf_addr[g*AW +: AW]) + AW'($past(xfer_len[g*CW +: CW]))));
    // R6
    bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req[g] && (xfer_len[g*CW +: CW] == '0 || xfer_len[g*CW +: CW] > buf_cnt[g*CW +: CW])) |-> !xfer_ack[g]);
  end

endmodule

// File: tb/test_dma_chain_ctx.sv
module test_dma_chain_ctx;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2, AW = 32, CW = 16;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] start = '0, xreq = '0;
  logic [NCH*AW-1:0] sptr = '0;
  logic [NCH*CW-1:0] xlen = '0;
  logic [NCH-1:0] ack, active, ready, done;
  logic [NCH*AW-1:0] baddr;
  logic [NCH*CW-1:0] bcnt;
  logic mem_req, mem_gnt, mem_rvalid = 0;
  logic [AW-1:0] mem_addr, mem_rdata = '0;
  logic stall_en = 0, gnt_tog = 0;
  logic [31:0] mem [256];
  logic [31:0] fa [16];
  int nf = 0, errors = 0, checks = 0;
  int dcnt [NCH];

  dma_chain_ctx #(.NCH(NCH), .AW(AW), .CW(CW)) i_dma_chain_ctx (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(sptr),
    .xfer_req(xreq), .xfer_len(xlen), .xfer_ack(ack), .active(active),
    .ready(ready), .done(done), .buf_addr(baddr), .buf_cnt(bcnt),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_gnt = mem_req && (!stall_en || gnt_tog);

  always @(posedge clk) begin
    gnt_tog <= !gnt_tog;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[mem_addr[9:2]];
      if (nf < 16) fa[nf] <= mem_addr;
      nf <= nf + 1;
    end
    for (int c = 0; c < NCH; c++) if (done[c]) dcnt[c] <= dcnt[c] + 1;
  end

  // len, expected address, expected count, expected done
  localparam logic [64:0] VEC [4] = '{
    {16'h0008, 32'h0000_1008, 16'h0018, 1'b0},
    {16'h0010, 32'h0000_1018, 16'h0008, 1'b0},
    {16'h0008, 32'h0000_2000, 16'h0010, 1'b0},
    {16'h0010, 32'h0000_2010, 16'h0000, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic kick(input int ch, input logic [31:0] p);
    @(negedge clk);
    start[ch] = 1'b1;
    sptr[ch*AW +: AW] = p;
    @(negedge clk);
    start[ch] = 1'b0;
  endtask

  task automatic settle(input int ch);
    int t = 0;
    @(negedge clk);
    while (active[ch] && !ready[ch] && t < 300) begin @(negedge clk); t++; end
  endtask

  task automatic xfer(input int ch, input logic [15:0] len);
    int t = 0;
    @(negedge clk);
    xreq[ch] = 1'b1;
    xlen[ch*CW +: CW] = len;
    #1;
    while (!ack[ch] && t < 100) begin @(negedge clk); #1; t++; end
    check(ack[ch], "R5 transfer acknowledged", 64'(ack[ch]), 64'd1);
    @(posedge clk); #1;
    xreq[ch] = 1'b0;
  endtask

  function automatic logic [31:0] addr_of(input int ch); return baddr[ch*AW +: AW]; endfunction
  function automatic logic [15:0] cnt_of(input int ch); return bcnt[ch*CW +: CW]; endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int c = 0; c < NCH; c++) dcnt[c] = 0;
    mem[8'h40] = 32'h1000; mem[8'h41] = 32'h0000_0020;
    mem[8'h42] = 32'h2000; mem[8'h43] = 32'h8000_0010;
    mem[8'h80] = 32'h3000; mem[8'h81] = 32'h0000_0000;
    mem[8'h82] = 32'h4000; mem[8'h83] = 32'h8000_0004;
    mem[8'hC0] = 32'h5000; mem[8'hC1] = 32'h8000_0000;
    mem[8'h00] = 32'h6000; mem[8'h01] = 32'h8000_0100;
    mem[8'h20] = 32'h7000; mem[8'h21] = 32'h8000_0100;

    repeat (3) @(negedge clk);
    check(active == 0 && ready == 0 && done == 0 && ack == 0 && !mem_req, "R1 reset idle",
          64'({active, ready, done, ack, mem_req}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(active == 0 && !mem_req, "R1 idle after reset", 64'({active, mem_req}), 64'd0);

    kick(0, 32'h100);
    settle(0);
    check(addr_of(0) == 32'h1000, "R2 R3 first buffer address", 64'(addr_of(0)), 64'h1000);
    check(cnt_of(0) == 16'h20, "R3 first count", 64'(cnt_of(0)), 64'h20);

    for (int v = 0; v < 4; v++) begin
      xfer(0, VEC[v][64:49]);
      settle(0);
      check(addr_of(0) == VEC[v][48:17], "R5 R7 vector address", 64'(addr_of(0)), 64'(VEC[v][48:17]));
      check(cnt_of(0) == VEC[v][16:1], "R5 R7 vector count", 64'(cnt_of(0)), 64'(VEC[v][16:1]));
      if (VEC[v][0]) begin
        repeat (2) @(negedge clk);
        check(dcnt[0] == 1, "R8 single done pulse", 64'(dcnt[0]), 64'd1);
        check(!active[0], "R8 idle after chain", 64'(active[0]), 64'd0);
      end
    end
    check(fa[0] == 32'h100 && fa[1] == 32'h104, "R3 word order", {fa[0], fa[1]}, {32'h100, 32'h104});
    check(fa[2] == 32'h108 && fa[3] == 32'h10C, "R4 pointer advanced by 8", {fa[2], fa[3]}, {32'h108, 32'h10C});

    stall_en = 1'b1;
    kick(1, 32'h200);
    settle(1);
    stall_en = 1'b0;
    check(addr_of(1) == 32'h4000 && cnt_of(1) == 16'h4, "R9 zero-count descriptor skipped",
          {32'(addr_of(1)), 32'(cnt_of(1))}, {32'h4000, 32'h4});
    check(nf == 8 && fa[6] == 32'h208, "R3 R4 fetch under grant stall", {32'(nf), fa[6]}, {32'd8, 32'h208});

    @(negedge clk);
    xreq[1] = 1'b1; xlen[CW +: CW] = 16'h8;
    for (int t = 0; t < 3; t++) begin
      #1; check(!ack[1], "R6 oversized request refused", 64'(ack[1]), 64'd0);
      @(negedge clk);
    end
    xlen[CW +: CW] = 16'h0;
    #1; check(!ack[1], "R6 zero-length request refused", 64'(ack[1]), 64'd0);
    @(negedge clk);
    xreq[1] = 1'b0;
    check(addr_of(1) == 32'h4000 && cnt_of(1) == 16'h4, "R6 state unchanged",
          {32'(addr_of(1)), 32'(cnt_of(1))}, {32'h4000, 32'h4});

    kick(1, 32'h100);
    repeat (6) @(negedge clk);
    check(nf == 8 && addr_of(1) == 32'h4000 && cnt_of(1) == 16'h4, "R2 start on active ignored",
          {32'(nf), 32'(addr_of(1))}, {32'd8, 32'h4000});

    xfer(1, 16'h4);
    repeat (2) @(negedge clk);
    check(dcnt[1] == 1 && !active[1], "R8 second channel done", {32'(dcnt[1]), 32'(active[1])}, {32'd1, 32'd0});

    kick(0, 32'h300);
    settle(0);
    repeat (2) @(negedge clk);
    check(!active[0] && dcnt[0] == 2 && cnt_of(0) == 0, "R9 zero-count last descriptor completes",
          {32'(active[0]), 32'(dcnt[0])}, {32'd0, 32'd2});

    @(negedge clk);
    start = 2'b11;
    sptr = {32'h80, 32'h0};
    @(negedge clk);
    start = 2'b00;
    settle(0);
    settle(1);
    check(ready == 2'b11, "R11 both channels loaded", 64'(ready), 64'd3);
    check(fa[11] == fa[10] + 4 && fa[13] == fa[12] + 4 && fa[10] != fa[12], "R11 descriptor words back to back",
          {fa[10], fa[12]}, {fa[11] - 32'd4, fa[13] - 32'd4});

    begin
      logic [1:0] first;
      @(negedge clk);
      xreq = 2'b11; xlen = {16'h1, 16'h1};
      #1;
      first = ack;
      check($countones(ack) == 1, "R10 one grant per cycle", 64'(ack), 64'd1);
      @(posedge clk); #1;
      check(ack == (~first & 2'b11), "R10 round-robin rotates", 64'(ack), 64'(~first & 2'b11));
      @(posedge clk); #1;
      xreq = 2'b00;
    end
    @(negedge clk);
    check(addr_of(0) == 32'h6001 && addr_of(1) == 32'h7001, "R5 R10 each channel advanced once",
          {addr_of(1), addr_of(0)}, {32'h7001, 32'h6001});
    check(cnt_of(0) == 16'hFF && cnt_of(1) == 16'hFF, "R5 counts reduced", {32'(cnt_of(1)), 32'(cnt_of(0))},
          {32'hFF, 32'hFF});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog run did not finish actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule